// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Aligner with Interworking Control

This block works on an E1 receive stream once basic frame alignment is held. It watches bit 1 of every non-alignment word and looks for the six-bit CRC-4 multiframe alignment sequence that the far end places in the odd frames 1 to 11 of each CRC-4 multiframe. It reports CRC-4 multiframe sync on an active-low flag. Sync is declared only after the sequence has been seen twice, one full multiframe apart.

A timer runs in parallel with the search. It divides the frame strobe into 8 ms reframe periods and counts up to a 400 ms limit. While the search is running, the timer drives the transmitted remote alarm indication (RAI). RAI pulses for one frame at each reframe boundary. When the limit is reached, one of two things happens, depending on the interworking setting:

- **Interworking on:** the block falls back to non-CRC operation and RAI goes low.
- **Interworking off:** RAI is held high while the search carries on.

Software can instead pin RAI to a fixed level. The transmitted E-bit level follows a control input, except while CRC-4 sync is held. In that case it carries the error-report level supplied by the CRC checker.

Top module: `crc4_mfa_top`

## Requirements
- R1: While `basic_ok` is 0, and after reset, `crc_sync_n` is 1 and `crc_noncrc` is 0. The reframe timer is also cleared, so a full 400 ms count restarts once `basic_ok` returns.
- R2: Each `nfas_vld` pulse delivers one bit on `nfas_bit`. A word completes a match when it and the five words before it, oldest first, read 0,0,1,0,1,1. The 8th word after that first match must also complete a match. `crc_sync_n` then falls to 0 in the cycle after that word.
- R3: If the 8th word after a first match does not complete a match, the search restarts and `crc_sync_n` stays 1.
- R4: This requirement applies when `auto_rai`=1, the search is running and the 400 ms limit has not yet been reached. A reframe boundary is every 64th `frame_tick` counted since alignment. At each boundary, `tx_rai` is 1 from the cycle after that tick until the cycle after the next tick. At all other times it is 0.
- R5: With `iw_en`=1 and the search still running, the 50th reframe boundary ends the search. From then on, `crc_noncrc` is 1, `tx_rai` is 0 under `auto_rai`, and later valid sequences do not set sync.
- R6: With `iw_en`=0, the 50th reframe boundary sets `tx_rai` to 1 under `auto_rai`, and the search continues. If sync is found later, `tx_rai` drops to 0.
- R7: With `auto_rai`=0, `tx_rai` equals `force_rai` in every state and in both interworking modes.
- R8: `tx_ebit` equals `ebit_rpt` while `crc_sync_n` is 0, and equals `ebit_ctl` otherwise.
- R9: `nfas_vld` pulses that arrive while `basic_ok` is 0 have no effect on the search or on `crc_sync_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One pulse per 125 us frame |
| basic_ok | input | 1 | Basic frame alignment held (1) |
| nfas_vld | input | 1 | Bit 1 of a non-alignment word is valid |
| nfas_bit | input | 1 | Bit 1 of the non-alignment word |
| iw_en | input | 1 | Interworking enable |
| auto_rai | input | 1 | RAI driven by the timer (1) or by `force_rai` (0) |
| force_rai | input | 1 | Fixed RAI level when `auto_rai` is 0 |
| ebit_ctl | input | 1 | E-bit level when not in CRC-4 sync |
| ebit_rpt | input | 1 | E-bit level from the CRC checker while in sync |
| crc_sync_n | output | 1 | CRC-4 multiframe sync, active low |
| crc_noncrc | output | 1 | Fallback to non-CRC operation |
| tx_rai | output | 1 | Transmit RAI level |
| tx_ebit | output | 1 | Transmit E-bit level |

## Verification
The bench drives four bit streams into the search, and each one separates a different behaviour:

- **All ones:** never matches. It lets the timer run to the end, so the reframe pulses and both expiry outcomes can be seen.
- **Correctly phased multiframes:** shows that sync comes exactly one multiframe after the first match.
- **One good multiframe followed by ones:** shows the confirmation failing and the search restarting.
- **Random bits:** tests the shift window against chance matches that fail to confirm.

The same streams are also run with basic alignment dropped, and with RAI forced. These runs show that the words are ignored while alignment is lost, and that the fixed RAI level overrides the timer.

// File: rtl/crc4_mfa_pkg.sv
package crc4_mfa_pkg;

  typedef enum logic [1:0] {
    MFA_SEARCH   = 2'd0,
    MFA_CONFIRM  = 2'd1,
    MFA_SYNC     = 2'd2,
    MFA_FALLBACK = 2'd3
  } mfa_state_e;

  // Compare the low len bits of a window with a pattern.
  function automatic logic seq_match(input logic [31:0] win,
                                     input logic [31:0] pat,
                                     input int unsigned len);
    logic [31:0] mask;
    mask = (32'd1 << len) - 32'd1;
    return ((win ^ pat) & mask) == 32'd0;
  endfunction

  // Timer-driven RAI level: low in sync, after expiry low only when interworking.
  function automatic logic rai_auto_level(input logic in_sync,
                                          input logic expired,
                                          input logic iw_en,
                                          input logic flick);
    if (in_sync) return 1'b0;
    if (expired) return !iw_en;
    return flick;
  endfunction

endpackage

// File: rtl/crc4_mfa_search.sv
module crc4_mfa_search
  import crc4_mfa_pkg::*;
#(
  parameter int unsigned SEQ_LEN      = 6,
  parameter logic [31:0] SEQ_PAT      = 32'b001011,
  parameter int unsigned WORDS_PER_MF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       basic_ok,
  input  logic       nfas_vld,
  input  logic       nfas_bit,
  input  logic       iw_en,
  input  logic       expired,
  output mfa_state_e state,
  output logic       seq_hit,
  output logic       confirm_due
);
  localparam int unsigned GW = (WORDS_PER_MF > 1) ? $clog2(WORDS_PER_MF) : 1;

  logic [SEQ_LEN-2:0] hist;
  logic [SEQ_LEN-1:0] window;
  logic [GW-1:0]      gap;

  assign window      = {hist, nfas_bit};
  assign seq_hit     = nfas_vld && seq_match(32'(window), SEQ_PAT, SEQ_LEN);
  assign confirm_due = nfas_vld && (state == MFA_CONFIRM) && (gap == GW'(WORDS_PER_MF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MFA_SEARCH;
      hist  <= '0;
      gap   <= '0;
    end else if (!basic_ok) begin
      state <= MFA_SEARCH;
      hist  <= '0;
      gap   <= '0;
    end else begin
      if (nfas_vld) hist <= window[SEQ_LEN-2:0];
      unique case (state)
        MFA_SEARCH: begin
          if (expired && iw_en) state <= MFA_FALLBACK;
          else if (seq_hit) begin
            state <= MFA_CONFIRM;
            gap   <= '0;
          end
        end
        MFA_CONFIRM: begin
          if (expired && iw_en) state <= MFA_FALLBACK;
          else if (confirm_due) state <= seq_hit ? MFA_SYNC : MFA_SEARCH;
          else if (nfas_vld) gap <= gap + GW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc4_mfa_iwtimer.sv
module crc4_mfa_iwtimer #(
  parameter int unsigned FRAMES_PER_RF = 64,
  parameter int unsigned RF_LIMIT      = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic basic_ok,
  input  logic active,
  input  logic frame_tick,
  output logic expired,
  output logic flick,
  output logic rf_edge
);
  localparam int unsigned FCW = (FRAMES_PER_RF > 1) ? $clog2(FRAMES_PER_RF) : 1;
  localparam int unsigned RCW = (RF_LIMIT > 1) ? $clog2(RF_LIMIT) : 1;

  logic [FCW-1:0] fcnt;
  logic [RCW-1:0] rcnt;
  logic           last_rf;

  assign rf_edge = active && !expired && frame_tick && (fcnt == FCW'(FRAMES_PER_RF - 1));
  assign last_rf = (rcnt == RCW'(RF_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt    <= '0;
      rcnt    <= '0;
      expired <= 1'b0;
      flick   <= 1'b0;
    end else if (!basic_ok) begin
      fcnt    <= '0;
      rcnt    <= '0;
      expired <= 1'b0;
      flick   <= 1'b0;
    end else if (!active) begin
      flick <= 1'b0;
    end else if (frame_tick && !expired) begin
      flick <= rf_edge && !last_rf;
      if (rf_edge) begin
        fcnt <= '0;
        if (last_rf) expired <= 1'b1;
        else rcnt <= rcnt + RCW'(1);
      end else begin
        fcnt <= fcnt + FCW'(1);
      end
    end
  end
endmodule

// File: rtl/crc4_mfa_top.sv
module crc4_mfa_top
  import crc4_mfa_pkg::*;
#(
  parameter int unsigned SEQ_LEN       = 6,
  parameter logic [31:0] SEQ_PAT       = 32'b001011,
  parameter int unsigned WORDS_PER_MF  = 8,
  parameter int unsigned FRAMES_PER_RF = 64,
  parameter int unsigned RF_LIMIT      = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic basic_ok,
  input  logic nfas_vld,
  input  logic nfas_bit,
  input  logic iw_en,
  input  logic auto_rai,
  input  logic force_rai,
  input  logic ebit_ctl,
  input  logic ebit_rpt,
  output logic crc_sync_n,
  output logic crc_noncrc,
  output logic tx_rai,
  output logic tx_ebit
);
  mfa_state_e state;
  logic       seq_hit;
  logic       confirm_due;
  logic       active;
  logic       expired;
  logic       flick;
  logic       rf_edge;
  logic       in_sync;
  logic       auto_lvl;

  crc4_mfa_search #(
    .SEQ_LEN     (SEQ_LEN),
    .SEQ_PAT     (SEQ_PAT),
    .WORDS_PER_MF(WORDS_PER_MF)
  ) search_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .basic_ok   (basic_ok),
    .nfas_vld   (nfas_vld),
    .nfas_bit   (nfas_bit),
    .iw_en      (iw_en),
    .expired    (expired),
    .state      (state),
    .seq_hit    (seq_hit),
    .confirm_due(confirm_due)
  );

  crc4_mfa_iwtimer #(
    .FRAMES_PER_RF(FRAMES_PER_RF),
    .RF_LIMIT     (RF_LIMIT)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .basic_ok  (basic_ok),
    .active    (active),
    .frame_tick(frame_tick),
    .expired   (expired),
    .flick     (flick),
    .rf_edge   (rf_edge)
  );

  assign active     = (state == MFA_SEARCH) || (state == MFA_CONFIRM);
  assign in_sync    = (state == MFA_SYNC);
  assign crc_sync_n = !in_sync;
  assign crc_noncrc = (state == MFA_FALLBACK);
  assign auto_lvl   = rai_auto_level(in_sync, expired, iw_en, flick);
  assign tx_rai     = auto_rai ? auto_lvl : force_rai;
  assign tx_ebit    = in_sync ? ebit_rpt : ebit_ctl;
endmodule

// File: rtl/crc4_mfa_chk.sv
module crc4_mfa_chk (
  input logic clk,
  input logic rst_n,
  input logic basic_ok,
  input logic nfas_vld,
  input logic frame_tick,
  input logic iw_en,
  input logic auto_rai,
  input logic crc_sync_n,
  input logic crc_noncrc,
  input logic tx_rai,
  input logic expired,
  input logic flick
);
  // R1
  basic_lost_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !basic_ok |=> crc_sync_n && !crc_noncrc);

  // R2
  sync_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crc_sync_n) |-> $past(nfas_vld) && $past(basic_ok));

  // R4
  flick_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flick) |-> $past(frame_tick));

  // R5
  noncrc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_noncrc) |-> $past(expired) && $past(iw_en));

  // R5
  noncrc_excl_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_noncrc |-> crc_sync_n);

  // R6
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rai && !iw_en && expired && crc_sync_n |-> tx_rai);
endmodule

bind crc4_mfa_top crc4_mfa_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .basic_ok  (basic_ok),
  .nfas_vld  (nfas_vld),
  .frame_tick(frame_tick),
  .iw_en     (iw_en),
  .auto_rai  (auto_rai),
  .crc_sync_n(crc_sync_n),
  .crc_noncrc(crc_noncrc),
  .tx_rai    (tx_rai),
  .expired   (expired),
  .flick     (flick)
);

// File: tb/crc4_mfa_top_tb_top.sv
`timescale 1ns/1ps
module crc4_mfa_top_tb_top;
  localparam int FPR = 64;
  localparam int RFL = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0, basic_ok = 1'b0, nfas_vld = 1'b0, nfas_bit = 1'b0;
  logic iw_en = 1'b0, auto_rai = 1'b1, force_rai = 1'b0, ebit_ctl = 1'b0, ebit_rpt = 1'b0;
  logic crc_sync_n, crc_noncrc, tx_rai, tx_ebit;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int fidx = 0;

  always #2.5 clk = ~clk;

  crc4_mfa_top dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .basic_ok(basic_ok),
    .nfas_vld(nfas_vld), .nfas_bit(nfas_bit), .iw_en(iw_en), .auto_rai(auto_rai),
    .force_rai(force_rai), .ebit_ctl(ebit_ctl), .ebit_rpt(ebit_rpt),
    .crc_sync_n(crc_sync_n), .crc_noncrc(crc_noncrc), .tx_rai(tx_rai), .tx_ebit(tx_ebit)
  );

  // Behavioural reference: phase 0 hunting, 1 awaiting repeat, 2 locked, 3 given up
  int m_phase = 0;
  int m_bits[$] = '{0, 0, 0, 0, 0};
  int m_words = 0;
  int m_frames = 0;
  int m_reframes = 0;
  bit m_over = 1'b0;
  bit m_pulse = 1'b0;

  always @(posedge clk) begin
    if (!rst_n || !basic_ok) begin
      m_phase = 0; m_bits = '{0, 0, 0, 0, 0}; m_words = 0;
      m_frames = 0; m_reframes = 0; m_over = 1'b0; m_pulse = 1'b0;
    end else begin
      int val;
      bit was_over;
      bit hunting;
      val = 0;
      foreach (m_bits[i]) val = val * 2 + m_bits[i];
      val = val * 2 + int'(nfas_bit);
      was_over = m_over;
      hunting = (m_phase < 2);
      if (!hunting) m_pulse = 1'b0;
      else if (frame_tick && !m_over) begin
        m_frames++;
        m_pulse = 1'b0;
        if (m_frames == FPR) begin
          m_frames = 0;
          m_reframes++;
          if (m_reframes == RFL) m_over = 1'b1;
          else m_pulse = 1'b1;
        end
      end
      if (hunting && was_over && iw_en) m_phase = 3;
      else if (nfas_vld) begin
        if (m_phase == 0 && val == 11) begin m_phase = 1; m_words = 0; end
        else if (m_phase == 1) begin
          m_words++;
          if (m_words == 8) m_phase = (val == 11) ? 2 : 0;
        end
      end
      if (nfas_vld) begin void'(m_bits.pop_front()); m_bits.push_back(int'(nfas_bit)); end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic e_rai;
    if (m_phase == 2) e_rai = 1'b0;
    else if (m_over) e_rai = !iw_en;
    else e_rai = m_pulse;
    chk(crc_sync_n, (m_phase != 2), "R2/R3 crc_sync_n");
    chk(crc_noncrc, (m_phase == 3), "R5 crc_noncrc");
    chk(tx_rai, auto_rai ? e_rai : force_rai, auto_rai ? "R4/R5/R6 tx_rai" : "R7 tx_rai");
    chk(tx_ebit, (m_phase == 2) ? ebit_rpt : ebit_ctl, "R8 tx_ebit");
  endtask

  task automatic step(input logic ft, input logic nv, input logic nb);
    @(negedge clk);
    compare_all();
    frame_tick = ft; nfas_vld = nv; nfas_bit = nb;
    ebit_rpt = $urandom_range(0, 1);
  endtask

  // src: 0 all ones, 1 correct multiframes, 2 random bits
  task automatic run_frames(input int n, input int src);
    for (int k = 0; k < n; k++) begin
      logic b;
      int pos;
      pos = fidx % 16;
      b = 1'b1;
      if (src == 1 && pos % 2 == 1 && pos <= 11) b = (pos == 5 || pos == 9 || pos == 11);
      if (src == 2) b = 1'($urandom_range(0, 1));
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, (pos % 2 == 1), b);
      step(1'b0, 1'b0, 1'b0);
      fidx++;
    end
  endtask

  task automatic realign();
    basic_ok = 1'b0;
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0);
    chk(crc_sync_n, 1'b1, "R1 sync cleared");
    chk(crc_noncrc, 1'b0, "R1 noncrc cleared");
    basic_ok = 1'b1;
    fidx = 0;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk(crc_sync_n, 1'b1, "R1 reset sync");
    chk(crc_noncrc, 1'b0, "R1 reset noncrc");
    // R9: good words while alignment lost do nothing
    run_frames(40, 1);
    chk(crc_sync_n, 1'b1, "R9 no sync without basic alignment");
    // R5: interworking with a far end lacking CRC-4
    iw_en = 1'b1; auto_rai = 1'b1;
    realign();
    run_frames(FPR * RFL + 20, 0);
    chk(crc_noncrc, 1'b1, "R5 fallback after limit");
    chk(tx_rai, 1'b0, "R5 rai low after limit");
    run_frames(64, 1);
    chk(crc_sync_n, 1'b1, "R5 search stopped");
    // R6: no interworking, RAI held high, search continues
    iw_en = 1'b0;
    realign();
    run_frames(FPR * RFL + 20, 0);
    chk(tx_rai, 1'b1, "R6 rai held high");
    chk(crc_noncrc, 1'b0, "R6 no fallback");
    run_frames(40, 1);
    chk(crc_sync_n, 1'b0, "R6 late sync");
    chk(tx_rai, 1'b0, "R6 rai low in sync");
    // R2 quick sync, then R1 loss while locked
    iw_en = 1'b1;
    realign();
    run_frames(40, 1);
    chk(crc_sync_n, 1'b0, "R2 sync on correct stream");
    realign();
    // R3: a single good multiframe followed by ones
    run_frames(16, 1);
    run_frames(100, 0);
    chk(crc_sync_n, 1'b1, "R3 no sync on single sequence");
    // random bits
    realign();
    run_frames(300, 2);
    // R7: forced RAI in both modes
    auto_rai = 1'b0; force_rai = 1'b1; iw_en = 1'b0;
    realign();
    run_frames(200, 0);
    chk(tx_rai, 1'b1, "R7 forced high");
    force_rai = 1'b0; iw_en = 1'b1; ebit_ctl = 1'b1;
    realign();
    run_frames(200, 2);
    chk(tx_rai, 1'b0, "R7 forced low");
    run_frames(40, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(195000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule